// File: doc/BRIEF.md
# Radio Coexistence Arbiter

This block decides, cycle by cycle, whether a Bluetooth baseband may use a 2.4 GHz radio that it shares with a WLAN device placed next to it. Four general-purpose lines link the two chips. A small configuration register selects one of five sharing schemes, and each scheme gives the same four lines different meanings:

- **Packet arbitration:** a request line, a confirm line and a WLAN busy status.
- **WLAN in charge:** one inbound "hold off" line.
- **Bluetooth in charge:** one outbound "hold off" line.
- **Host-chosen direction:** both the inbound and the outbound hold-off lines are wired, and the host picks the direction.
- **Alternating medium:** one inbound "medium free" window line.

The baseband issues a one-cycle request strobe with a priority. If the selected scheme allows the radio, the block returns a one-cycle grant pulse. If not, the request is held pending until it is allowed. Inbound lines pass through a synchronizer before they are used. Every output is registered.

Top module: `coex_arbiter`

## Requirements
- R1: After a synchronous reset, the configuration is enabled, packet-arbitration mode (code 0), threshold DEF_THR, host direction bit 0. `bt_grant`, `gpio_oe` and `gpio_out` are all 0.
- R2: `cfg_we` with `cfg_mode` in 0..4 loads mode, enable, threshold and direction bit together (0 packet arbitration, 1 WLAN in charge, 2 Bluetooth in charge, 3 host-chosen, 4 alternating medium). A write with a code of 5..7 is dropped entirely.
- R3: While disabled, all four lines are undriven and low, and every request is granted.
- R4: In mode 0, line bit 1 is driven high while a request is active. The request is granted when its priority is at or above the threshold, when status bit 2 is low (WLAN idle), or when confirm bit 0 is high.
- R5: In mode 1, no line is driven, and a high level on bit 0 blocks every grant.
- R6: In mode 2, line bit 1 is driven high while a request is active, and every request is granted.
- R7: In mode 3, line bit 1 is always driven. With the direction bit at 1 it behaves as in R6; with the bit at 0, bit 1 is driven low and grants follow R5.
- R8: In mode 4, no line is driven, and a request is granted only while bit 0 (medium free) is high.
- R9: A request that is not allowed stays pending until it is granted. A new strobe merges into the pending request, keeping the higher priority. A grant clears the pending request.
- R10: Inbound lines take effect after SYNC_STAGES register stages. A grant, and any line output, appears one clock after the decision.
- R11: Bits 0, 2 and 3 are never driven. Any undriven output is low. Lines that the current mode does not use have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Scheme code 0..4 |
| cfg_en | input | 1 | Coexistence enable |
| cfg_thr | input | PRIO_W | Priority threshold for packet arbitration |
| cfg_bt_master | input | 1 | Host-chosen direction: 1 = Bluetooth in charge |
| bt_req | input | 1 | One-cycle radio request strobe from the baseband |
| bt_prio | input | PRIO_W | Priority of the strobe |
| gpio_in | input | 4 | Sampled levels of the four coexistence lines |
| gpio_out | output | 4 | Values driven on the lines |
| gpio_oe | output | 4 | Output enables of the lines |
| bt_grant | output | 1 | One-cycle grant pulse to the baseband |

## Verification
The bench builds the block with SYNC_STAGES = 3, PRIO_W = 3 and DEF_THR = 5. The non-default synchronizer depth exposes any latency that is hard-wired to two stages. A three-bit priority makes every level, including the threshold boundaries at 0 and 7, reachable by random strobes. Seeded random configuration writes, including invalid codes, move the block through all five modes. During this, slowly toggling line levels create long inhibits that force pending requests and priority merges. Directed cases cover the exact release latency and the equal-to-threshold boundary.

// File: rtl/coex_pkg.sv
package coex_pkg;
  localparam int LINES = 4;
  // line roles (bit index on the coexistence lines)
  localparam int L_IN0  = 0; // confirm / hold-off in / medium free
  localparam int L_REQ  = 1; // request / hold-off out
  localparam int L_STAT = 2; // WLAN busy status
  localparam int L_OPT  = 3; // spare line

  typedef enum logic [2:0] {
    MODE_PTA = 3'd0,
    MODE_WLM = 3'd1,
    MODE_BTM = 3'd2,
    MODE_TWO = 3'd3,
    MODE_ALT = 3'd4
  } coex_mode_e;

  function automatic logic mode_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CW-W-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[CW-1 -: W];
endmodule

// File: rtl/coex_cfg.sv
module coex_cfg
  import coex_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter logic [PRIO_W-1:0] DEF_THR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        wmode,
  input  logic              wen,
  input  logic [PRIO_W-1:0] wthr,
  input  logic              wbtm,
  output coex_mode_e        mode_q,
  output logic              en_q,
  output logic [PRIO_W-1:0] thr_q,
  output logic              btm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PTA;
      en_q   <= 1'b1;
      thr_q  <= DEF_THR;
      btm_q  <= 1'b0;
    end else if (we && mode_ok(wmode)) begin
      mode_q <= coex_mode_e'(wmode);
      en_q   <= wen;
      thr_q  <= wthr;
      btm_q  <= wbtm;
    end
  end
endmodule

// File: rtl/coex_policy.sv
module coex_policy
  import coex_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  coex_mode_e        mode,
  input  logic              en,
  input  logic [PRIO_W-1:0] thr,
  input  logic              btm,
  input  logic [LINES-1:0]  line_s,
  input  logic              act,
  input  logic [PRIO_W-1:0] aprio,
  output logic              allow,
  output logic [LINES-1:0]  oe_nx,
  output logic [LINES-1:0]  out_nx
);
  logic unused_spare;
  assign unused_spare = line_s[L_OPT];

  always_comb begin
    allow  = 1'b1;
    oe_nx  = '0;
    out_nx = '0;
    if (en) begin
      case (mode)
        MODE_PTA: begin
          oe_nx[L_REQ]  = 1'b1;
          out_nx[L_REQ] = act;
          allow = (aprio >= thr) | ~line_s[L_STAT] | line_s[L_IN0];
        end
        MODE_WLM: allow = ~line_s[L_IN0];
        MODE_BTM: begin
          oe_nx[L_REQ]  = 1'b1;
          out_nx[L_REQ] = act;
        end
        MODE_TWO: begin
          oe_nx[L_REQ] = 1'b1;
          if (btm) out_nx[L_REQ] = act;
          else     allow = ~line_s[L_IN0];
        end
        MODE_ALT: allow = line_s[L_IN0];
        default: allow = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int PRIO_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [PRIO_W-1:0] DEF_THR = 3'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_en,
  input  logic [PRIO_W-1:0] cfg_thr,
  input  logic              cfg_bt_master,
  input  logic              bt_req,
  input  logic [PRIO_W-1:0] bt_prio,
  input  logic [3:0]        gpio_in,
  output logic [3:0]        gpio_out,
  output logic [3:0]        gpio_oe,
  output logic              bt_grant
);
  coex_mode_e        mode_q;
  logic              en_q, btm_q;
  logic [PRIO_W-1:0] thr_q;
  logic [LINES-1:0]  line_s;
  logic              pend_q;
  logic [PRIO_W-1:0] pprio_q;
  logic              act, allow;
  logic [PRIO_W-1:0] aprio;
  logic [LINES-1:0]  oe_nx, out_nx;

  coex_cfg #(.PRIO_W(PRIO_W), .DEF_THR(DEF_THR)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wmode(cfg_mode), .wen(cfg_en),
    .wthr(cfg_thr), .wbtm(cfg_bt_master),
    .mode_q(mode_q), .en_q(en_q), .thr_q(thr_q), .btm_q(btm_q)
  );

  coex_sync #(.W(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(gpio_in), .dout(line_s)
  );

  // merge a fresh strobe into a pending request, keeping the higher priority
  assign act = bt_req | pend_q;
  always_comb begin
    if (pend_q && bt_req) aprio = (bt_prio > pprio_q) ? bt_prio : pprio_q;
    else if (pend_q)      aprio = pprio_q;
    else                  aprio = bt_prio;
  end

  coex_policy #(.PRIO_W(PRIO_W)) pol_i (
    .mode(mode_q), .en(en_q), .thr(thr_q), .btm(btm_q), .line_s(line_s),
    .act(act), .aprio(aprio), .allow(allow), .oe_nx(oe_nx), .out_nx(out_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pprio_q  <= '0;
      bt_grant <= 1'b0;
      gpio_oe  <= '0;
      gpio_out <= '0;
    end else begin
      pend_q   <= act & ~allow;
      pprio_q  <= aprio;
      bt_grant <= act & allow;
      gpio_oe  <= oe_nx;
      gpio_out <= out_nx;
    end
  end
endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk
  import coex_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bt_req,
  input logic       bt_grant,
  input logic [3:0] gpio_oe,
  input logic [3:0] gpio_out,
  input logic       pend_q,
  input coex_mode_e mode_q,
  input logic       en_q,
  input logic [3:0] line_s
);
  // R9
  grant_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    bt_grant |-> ($past(bt_req) || $past(pend_q)));
  // R9
  grant_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
    bt_grant |-> !pend_q);
  // R11
  spare_lines_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    (gpio_oe & 4'b1101) == 4'b0000);
  // R11
  undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
    (gpio_out & ~gpio_oe) == 4'b0000);
  // R5
  wlan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && $past(mode_q) == MODE_WLM && $past(line_s[0])) |-> !bt_grant);
  // R8
  medium_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && $past(mode_q) == MODE_ALT && !$past(line_s[0])) |-> !bt_grant);
  // R6
  bt_in_charge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && $past(mode_q) == MODE_BTM && $past(bt_req)) |-> bt_grant);
  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> gpio_oe == 4'b0000);
endmodule

bind coex_arbiter coex_arbiter_chk chk_i (
  .clk(clk), .rst(rst), .bt_req(bt_req), .bt_grant(bt_grant),
  .gpio_oe(gpio_oe), .gpio_out(gpio_out), .pend_q(pend_q),
  .mode_q(mode_q), .en_q(en_q), .line_s(line_s)
);

// File: tb/coex_arbiter_tb_top.sv
module coex_arbiter_tb_top;
  localparam int PW = 3;
  localparam int SS = 3;
  localparam logic [PW-1:0] DT = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_en = 0, cfg_btm = 0, bt_req = 0;
  logic [2:0]    cfg_mode = 0;
  logic [PW-1:0] cfg_thr = 0, bt_prio = 0;
  logic [3:0]    gpio_in = 0;
  logic [3:0]    gpio_out, gpio_oe;
  logic          bt_grant;

  coex_arbiter #(.PRIO_W(PW), .SYNC_STAGES(SS), .DEF_THR(DT)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
    .cfg_thr(cfg_thr), .cfg_bt_master(cfg_btm), .bt_req(bt_req), .bt_prio(bt_prio),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .bt_grant(bt_grant)
  );

  int checks = 0;
  int errors = 0;
  string ctx = "";
  string e_tag = "R1";

  // reference state, derived from the requirements
  logic [2:0]    m_mode;
  logic          m_en, m_btm, m_pend;
  logic [PW-1:0] m_thr, m_pprio;
  logic [3:0]    m_sync [SS];
  logic          e_grant, obs_grant;
  logic [3:0]    e_oe, e_out;

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 3'd0; m_en = 1'b1; m_thr = DT; m_btm = 1'b0;
    m_pend = 1'b0; m_pprio = '0;
    for (int i = 0; i < SS; i++) m_sync[i] = 4'h0;
    e_grant = 1'b0; e_oe = 4'h0; e_out = 4'h0;
  endtask

  // predicts the outputs after the coming edge from the inputs now driven
  task automatic model_eval();
    logic act, alw;
    logic [PW-1:0] ap;
    logic [3:0] ls, oe, out;
    ls  = m_sync[SS-1];
    act = bt_req | m_pend;
    if (m_pend) ap = (bt_req && bt_prio > m_pprio) ? bt_prio : m_pprio;
    else        ap = bt_prio;
    alw = 1'b1; oe = 4'h0; out = 4'h0; e_tag = "R3";
    if (m_en) begin
      case (m_mode)
        3'd0: begin e_tag = "R4"; oe = 4'b0010; out = {2'b0, act, 1'b0};
                    alw = (ap >= m_thr) || !ls[2] || ls[0]; end
        3'd1: begin e_tag = "R5"; alw = !ls[0]; end
        3'd2: begin e_tag = "R6"; oe = 4'b0010; out = {2'b0, act, 1'b0}; end
        3'd3: begin e_tag = "R7"; oe = 4'b0010;
                    if (m_btm) out = {2'b0, act, 1'b0}; else alw = !ls[0]; end
        default: begin e_tag = "R8"; alw = ls[0]; end
      endcase
    end
    e_grant = act & alw; e_oe = oe; e_out = out;
    m_pend = act & !alw; m_pprio = ap;
    for (int i = SS - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = gpio_in;
    if (cfg_we && cfg_mode <= 3'd4) begin
      m_mode = cfg_mode; m_en = cfg_en; m_thr = cfg_thr; m_btm = cfg_btm;
    end
  endtask

  task automatic step(input logic req, input logic [PW-1:0] prio, input logic [3:0] gin);
    string tag;
    @(negedge clk);
    tag = (ctx.len() > 0) ? ctx : e_tag;
    obs_grant = bt_grant;
    chk(tag, "grant", {3'b0, bt_grant}, {3'b0, e_grant});
    chk(tag, "oe", gpio_oe, e_oe);
    chk(tag, "out", gpio_out, e_out);
    bt_req = req; bt_prio = prio; gpio_in = gin; cfg_we = 1'b0;
    model_eval();
  endtask

  task automatic wcfg(input logic [2:0] md, input logic en, input logic [PW-1:0] thr,
                      input logic btm, input logic [3:0] gin);
    @(negedge clk);
    chk((ctx.len() > 0) ? ctx : e_tag, "grant", {3'b0, bt_grant}, {3'b0, e_grant});
    cfg_we = 1'b1; cfg_mode = md; cfg_en = en; cfg_thr = thr; cfg_btm = btm;
    bt_req = 1'b0; gpio_in = gin;
    model_eval();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] gl;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state, sampled before the first active edge
    chk("R1", "grant", {3'b0, bt_grant}, 4'h0);
    chk("R1", "oe", gpio_oe, 4'h0);
    chk("R1", "out", gpio_out, 4'h0);
    model_reset();
    model_eval();

    // R2 invalid code dropped: still packet arbitration, WLAN busy, low priority pends
    ctx = "R2";
    wcfg(3'd6, 1'b0, 3'd0, 1'b1, 4'b0100);
    repeat (SS + 1) step(1'b0, 0, 4'b0100);
    step(1'b1, 3'd1, 4'b0100);
    repeat (3) step(1'b0, 0, 4'b0100);
    chk("R2", "grant", {3'b0, obs_grant}, 4'h0);

    // R4 threshold boundary: equal priority wins, one below pends until confirm
    ctx = "R4";
    wcfg(3'd0, 1'b1, 3'd4, 1'b0, 4'b0100);
    step(1'b0, 0, 4'b0100);
    step(1'b1, 3'd4, 4'b0100);
    step(1'b0, 0, 4'b0100);
    chk("R4", "grant at threshold", {3'b0, obs_grant}, 4'h1);
    step(1'b1, 3'd3, 4'b0100);
    repeat (3) step(1'b0, 0, 4'b0100);
    ctx = "R9";
    step(1'b1, 3'd6, 4'b0100);
    repeat (2) step(1'b0, 0, 4'b0100);
    step(1'b1, 3'd3, 4'b0101);
    repeat (SS + 3) step(1'b0, 0, 4'b0101);

    // R10 exact release latency in WLAN-in-charge mode
    ctx = "R10";
    wcfg(3'd1, 1'b1, 3'd0, 1'b0, 4'b0001);
    repeat (SS + 1) step(1'b0, 0, 4'b0001);
    step(1'b1, 3'd2, 4'b0001);
    repeat (4) step(1'b0, 0, 4'b0001);
    step(1'b0, 0, 4'b0000);
    for (int k = 1; k <= SS + 1; k++) begin
      step(1'b0, 0, 4'b0000);
      chk("R10", "release latency", {3'b0, obs_grant}, {3'b0, (k == SS + 1)});
    end

    // R7 both host directions
    ctx = "R7";
    wcfg(3'd3, 1'b1, 3'd0, 1'b1, 4'b0001);
    repeat (SS) step(1'b1, 3'd0, 4'b0001);
    wcfg(3'd3, 1'b1, 3'd0, 1'b0, 4'b0001);
    repeat (SS + 2) step(1'b1, 3'd0, 4'b1111);
    repeat (SS + 2) step(1'b0, 3'd0, 4'b0000);

    // random phase, tags follow the active mode (R3..R8, R11 through spare lines)
    ctx = "";
    gl = 4'h0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 63) == 0) begin
        wcfg(3'($urandom_range(0, 7)), ($urandom_range(0, 7) != 0),
             PW'($urandom), 1'($urandom), gl);
      end else begin
        for (int b = 0; b < 4; b++)
          if ($urandom_range(0, 5) == 0) gl[b] = ~gl[b];
        step(($urandom_range(0, 2) == 0), PW'($urandom), gl);
      end
    end
    step(1'b0, 0, gl);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule